// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Flag Register

This block is the integer execution unit of a small processor core. It takes two 32-bit register operands, a source value A and a destination value B, together with a 4-bit operation selector, and produces a 32-bit result. That result is intended for write-back into the register that supplied B. The supported operations are addition, subtraction (B minus A), bitwise AND and bitwise exclusive-OR. The result path is purely combinational.

Alongside the result, the unit keeps three single-bit status flags in a register: overflow, zero and sign. The flags are loaded on a rising clock edge only when the caller raises the flag-write enable. Because the enable is separate, the same adder can serve address arithmetic without disturbing the status a later conditional branch depends on. Selector values outside the four defined operations produce a zero result and never touch the flags.

Top module: `aluFlagUnit`

## Requirements
- R1: Selector 0 (addition) drives `result` with (B + A) modulo 2^32 in the same cycle.
- R2: Selector 1 (subtraction) drives `result` with (B − A) modulo 2^32, with A subtracted from B.
- R3: Selector 2 drives `result` with the bitwise AND of A and B.
- R4: Selector 3 drives `result` with the bitwise exclusive-OR of A and B.
- R5: Selectors 4 to 15 drive `result` to zero and leave all three flags unchanged, even when `setFlags` is high.
- R6: While `rstN` is low, all three flags read 0.
- R7: When `setFlags` is high and the selector is 0 to 3, after the next rising edge `zeroFlag` is 1 exactly when the 32-bit result was zero, and `signFlag` equals bit 31 of that result.
- R8: For addition with flags written, `ovfFlag` becomes 1 exactly when A and B have the same sign bit and the result's sign bit differs from them.
- R9: For subtraction with flags written, `ovfFlag` becomes 1 exactly when A and B have different sign bits and the result's sign bit differs from B's.
- R10: For AND and exclusive-OR with flags written, `ovfFlag` becomes 0.
- R11: When `setFlags` is low, all three flags keep their values across the clock edge, whatever the selector and operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; flags load on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset; clears the flags |
| opA | input | 32 | Source operand A |
| opB | input | 32 | Destination operand B |
| funcSel | input | 4 | Operation selector: 0 add, 1 subtract, 2 AND, 3 XOR |
| setFlags | input | 1 | Flag-write enable for the current operation |
| result | output | 32 | Combinational operation result |
| ovfFlag | output | 1 | Registered signed-overflow flag |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |

## Verification
The bench targets the operand extremes where signed overflow hides. It adds two large positives and two minimum values, and it subtracts the minimum value from zero and from a positive. A unit that reversed the subtraction order, or took the overflow rule from the wrong operand, would report the wrong flag or result on exactly these cases. It also sends a zero result into the flags and then sends a negative one. This catches a zero or sign flag tied to the wrong bit, and catches overflow left set by a logic operation that follows an overflowing add. It then sends every undefined selector and every flag-disabled operation right after flags were set to a known non-zero state. A unit that loaded flags anyway, or gave a stale result for an undefined selector, shows up at once.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int FUNC_W = 4;

  typedef enum logic [1:0] {
    RES_ARITH = 2'd0,
    RES_AND   = 2'd1,
    RES_XOR   = 2'd2,
    RES_ZERO  = 2'd3
  } resSel_t;

  typedef struct packed {
    logic    doSub;
    resSel_t resSel;
    logic    flagWrite;
    logic    ovfAllowed;
  } aluStrobes_t;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic sign;
  } aluFlags_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic [FUNC_W-1:0] funcSel,
  input  logic              setFlags,
  output aluStrobes_t       strobes
);
  localparam logic [FUNC_W-1:0] FN_ADD = FUNC_W'(0);
  localparam logic [FUNC_W-1:0] FN_SUB = FUNC_W'(1);
  localparam logic [FUNC_W-1:0] FN_AND = FUNC_W'(2);
  localparam logic [FUNC_W-1:0] FN_XOR = FUNC_W'(3);

  always_comb begin
    strobes.doSub      = 1'b0;
    strobes.resSel     = RES_ZERO;
    strobes.flagWrite  = 1'b0;
    strobes.ovfAllowed = 1'b0;
    unique case (funcSel)
      FN_ADD: begin
        strobes.resSel     = RES_ARITH;
        strobes.flagWrite  = setFlags;
        strobes.ovfAllowed = 1'b1;
      end
      FN_SUB: begin
        strobes.doSub      = 1'b1;
        strobes.resSel     = RES_ARITH;
        strobes.flagWrite  = setFlags;
        strobes.ovfAllowed = 1'b1;
      end
      FN_AND: begin
        strobes.resSel    = RES_AND;
        strobes.flagWrite = setFlags;
      end
      FN_XOR: begin
        strobes.resSel    = RES_XOR;
        strobes.flagWrite = setFlags;
      end
      default: begin
        strobes.resSel = RES_ZERO;
      end
    endcase
  end
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flags
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] aEff;
  logic [DATA_W-1:0] sumVal;
  logic              ovfNext;
  aluFlags_t         flagsNext;

  // Shared adder: subtraction is B + ~A + 1, so B - A.
  assign aEff   = strobes.doSub ? ~opA : opA;
  assign sumVal = opB + aEff + DATA_W'(strobes.doSub);

  // Signed overflow: effective addends agree in sign, sum sign differs from B.
  assign ovfNext = strobes.ovfAllowed &&
                   (aEff[MSB] == opB[MSB]) && (sumVal[MSB] != opB[MSB]);

  always_comb begin
    unique case (strobes.resSel)
      RES_ARITH: result = sumVal;
      RES_AND:   result = opA & opB;
      RES_XOR:   result = opA ^ opB;
      default:   result = '0;
    endcase
  end

  assign flagsNext.ovf  = ovfNext;
  assign flagsNext.zero = (result == '0);
  assign flagsNext.sign = result[MSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  flags <= '0;
    else if (strobes.flagWrite) flags <= flagsNext;
  end

  // R7: zero and sign flags track the result that was written.
  assert_zero_sign_track_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flagWrite |=> (flags.zero == ($past(result) == '0)) &&
                          (flags.sign == $past(result[MSB])));

  // R11: flags frozen when no write strobe.
  assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.flagWrite |=> $stable(flags));

  // R10: logic operations clear overflow.
  assert_logic_clears_ovf_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.flagWrite && strobes.resSel != RES_ARITH) |=> !flags.ovf);
endmodule

// File: rtl/aluFlagUnit.sv
module aluFlagUnit
  import aluPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  input  logic [3:0]  funcSel,
  input  logic        setFlags,
  output logic [31:0] result,
  output logic        ovfFlag,
  output logic        zeroFlag,
  output logic        signFlag
);
  aluStrobes_t strobes;
  aluFlags_t   flags;

  aluControl uCtrl (
    .funcSel  (funcSel),
    .setFlags (setFlags),
    .strobes  (strobes)
  );

  aluDatapath #(.DATA_W(32)) uPath (
    .clk     (clk),
    .rstN    (rstN),
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .flags   (flags)
  );

  assign ovfFlag  = flags.ovf;
  assign zeroFlag = flags.zero;
  assign signFlag = flags.sign;

  // R5: undefined selectors give zero and never move the flags.
  assert_undef_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel > 4'd3) |-> (result == 32'd0));

  assert_undef_keeps_flags_R5: assert property (@(posedge clk) disable iff (!rstN)
    (funcSel > 4'd3) |=> $stable({ovfFlag, zeroFlag, signFlag}));

  // R11: disabled writes keep flags at the ports.
  assert_no_flag_write_R11: assert property (@(posedge clk) disable iff (!rstN)
    !setFlags |=> $stable({ovfFlag, zeroFlag, signFlag}));
endmodule

// File: tb/tb_aluFlagUnit.sv
module tb_aluFlagUnit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [31:0] opA, opB;
  logic [3:0]  funcSel;
  logic        setFlags;
  logic [31:0] result;
  logic        ovfFlag, zeroFlag, signFlag;

  int testsRun = 0;
  int testsFailed = 0;
  logic expOvf = 1'b0, expZero = 1'b0, expSign = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aluFlagUnit dut (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB), .funcSel(funcSel),
    .setFlags(setFlags), .result(result), .ovfFlag(ovfFlag),
    .zeroFlag(zeroFlag), .signFlag(signFlag)
  );

  function automatic logic [31:0] refResult(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      4'd0: return b + a;
      4'd1: return b - a;
      4'd2: return a & b;
      4'd3: return a ^ b;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic refOvf(input logic [3:0] f, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    r = refResult(f, a, b);
    if (f == 4'd0) return (a[31] == b[31]) && (r[31] != a[31]);
    if (f == 4'd1) return (a[31] != b[31]) && (r[31] != b[31]);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    testsRun++;
    if (got !== exp) begin
      testsFailed++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Apply one operation, check result, clock it, check flags.
  task automatic runOp(input string req, input logic [3:0] f, input logic [31:0] a,
                       input logic [31:0] b, input logic sf);
    logic [31:0] expRes;
    @(negedge clk);
    funcSel = f; opA = a; opB = b; setFlags = sf;
    expRes = refResult(f, a, b);
    #1;
    check(req, result, expRes);
    if (sf && f <= 4'd3) begin
      expOvf  = refOvf(f, a, b);
      expZero = (expRes == 32'd0);
      expSign = expRes[31];
    end
    @(negedge clk);
    check(req, {29'd0, ovfFlag, zeroFlag, signFlag}, {29'd0, expOvf, expZero, expSign});
    setFlags = 1'b0;
  endtask

  task automatic testReset;
    rstN = 1'b0; setFlags = 1'b1; funcSel = 4'd1; opA = 32'd1; opB = 32'h8000_0000;
    repeat (2) @(negedge clk);
    check("R6 reset", {29'd0, ovfFlag, zeroFlag, signFlag}, 32'd0);
    setFlags = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R6 after release", {29'd0, ovfFlag, zeroFlag, signFlag}, 32'd0);
  endtask

  task automatic testAdd;
    runOp("R1 add small", 4'd0, 32'd5, 32'd7, 1'b1);
    runOp("R8 add pos ovf", 4'd0, 32'h7fff_ffff, 32'd1, 1'b1);
    runOp("R8 add min+min", 4'd0, 32'h8000_0000, 32'h8000_0000, 1'b1);
    runOp("R7 add to zero", 4'd0, 32'hffff_ffff, 32'd1, 1'b1);
    runOp("R8 add neg no ovf", 4'd0, 32'hffff_fff0, 32'd3, 1'b1);
  endtask

  task automatic testSub;
    runOp("R2 sub order", 4'd1, 32'd3, 32'd10, 1'b1);
    runOp("R9 zero minus min", 4'd1, 32'h8000_0000, 32'd0, 1'b1);
    runOp("R9 pos minus min", 4'd1, 32'h8000_0000, 32'd5, 1'b1);
    runOp("R9 min minus one", 4'd1, 32'd1, 32'h8000_0000, 1'b1);
    runOp("R7 sub equal", 4'd1, 32'h1234_5678, 32'h1234_5678, 1'b1);
  endtask

  task automatic testLogic;
    runOp("R8 prime ovf", 4'd0, 32'h7fff_ffff, 32'h7fff_ffff, 1'b1);
    runOp("R3 R10 and", 4'd2, 32'hf0f0_ff00, 32'h8ff0_0ff0, 1'b1);
    runOp("R8 prime ovf2", 4'd0, 32'h7fff_ffff, 32'h7fff_ffff, 1'b1);
    runOp("R4 R10 xor", 4'd3, 32'haaaa_5555, 32'h5555_5555, 1'b1);
    runOp("R4 xor zero", 4'd3, 32'hdead_beef, 32'hdead_beef, 1'b1);
  endtask

  task automatic testUndefined;
    runOp("R8 prime flags", 4'd0, 32'h7fff_ffff, 32'd1, 1'b1);
    for (int f = 4; f < 16; f++)
      runOp("R5 undefined", 4'(f), 32'h1357_9bdf, 32'h8000_0001, 1'b1);
  endtask

  task automatic testHold;
    runOp("R7 prime neg", 4'd1, 32'd1, 32'd0, 1'b1);
    runOp("R11 add no write", 4'd0, 32'd1, 32'hffff_ffff, 1'b0);
    runOp("R11 sub no write", 4'd1, 32'h8000_0000, 32'd0, 1'b0);
    runOp("R11 xor no write", 4'd3, 32'd9, 32'd9, 1'b0);
  endtask

  task automatic testRandom;
    for (int i = 0; i < 200; i++)
      runOp("R1 R2 R3 R4 random", 4'($urandom_range(0, 5)), $urandom, $urandom, 1'($urandom));
  endtask

  initial begin
    fork
      begin
        opA = '0; opB = '0; funcSel = '0; setFlags = 1'b0;
        testReset;
        testAdd;
        testSub;
        testLogic;
        testUndefined;
        testHold;
        testRandom;
      end
      begin
        repeat (20000) @(posedge clk);
        testsRun++; testsFailed++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule